// File: doc/BRIEF.md
# Wraparound Burst Address Sequencer

This block produces the low address bits of a four-beat burst for a synchronous burst memory. A new access is strobed on one of two active-low strobes, one from the processor side and one from the controller side. On that strobe, with the chip selected, the block captures the two low bits of the start address. After that, each clock edge on which the active-low advance input is low, with no strobe present, steps the burst to its next beat. The address wraps around within the aligned group of four.

A static order input chooses between two orders. In the interleaved order (order input high), each beat address is the start address XOR the beat count. In the linear order (order input low), each beat address is the start address plus the beat count, modulo four. The block has no memory array, no upper address register and no data path. It only supplies the registered low address bits and the beat index that a surrounding memory controller uses. Both outputs come straight from flops.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous active-high reset is high at a clock edge, both the address output and the beat index become 00 at that edge.
- R2: At an edge where either strobe is low and the chip select is high, the address output takes the start address bits and the beat index becomes 00. This happens whatever the level of the advance input.
- R3: At an edge where a strobe is low but the chip select is low, nothing is loaded and nothing advances: both outputs keep their values.
- R4: At an edge where the advance input is low and both strobes are high, the beat index increments by one modulo four.
- R5: With the order input high, the address output equals the captured start address XOR the beat index. From start 01 the order is 01, 00, 11, 10.
- R6: With the order input low, the address output equals the captured start address plus the beat index, modulo four. From start 11 the order is 11, 00, 01, 10.
- R7: Four advances after a load, the address output is back at the start address and the beat index is back at 00.
- R8: At an edge where the advance input is high and both strobes are high, both outputs hold their values (burst suspend), and a later advance resumes from the held beat.
- R9: A strobe in the middle of a burst, with the chip selected, restarts the sequence from the new start address at beat 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | 2 | Low start address bits, captured on a load |
| proc_strobe_n | input | 1 | Processor-side access strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side access strobe, active low |
| chip_sel | input | 1 | Chip selected, active high; qualifies both strobes |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_ilv | input | 1 | 1 = interleaved order, 0 = linear order; static during a burst |
| burst_addr | output | 2 | Registered current low address bits |
| beat_idx | output | 2 | Registered beat count since the last load |

## Verification
A corrupted beat count shows up at once in the beat index. It also shows up in the address output on the same registered edge, because every later address is a fixed function of the captured start and the count. A lost or stale start address appears on the first edge after the load, where the output must equal the presented bits. An order selection that is wired the wrong way can hide at start 00, where the two orders agree on the second beat. It cannot hide at the second beat from start 01 or from start 11. A wrong wrap shows on the fourth advance, where the address must come back to its start.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_LOAD    = 2'd1,
    OP_ADVANCE = 2'd2
  } burst_op_e;

endpackage

// File: rtl/burst_ctrl_decode.sv
module burst_ctrl_decode
  import burst_seq_pkg::*;
(
  input  logic      proc_strobe_n,
  input  logic      ctrl_strobe_n,
  input  logic      chip_sel,
  input  logic      adv_n,
  output burst_op_e op
);

  logic any_strobe;

  // A strobe while deselected blocks advancing too: it is a deselect cycle.
  assign any_strobe = ~proc_strobe_n | ~ctrl_strobe_n;

  always_comb begin
    if (any_strobe && chip_sel)
      op = OP_LOAD;
    else if (!any_strobe && !adv_n)
      op = OP_ADVANCE;
    else
      op = OP_HOLD;
  end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  burst_op_e         op,
  input  logic [BEAT_W-1:0] start_addr,
  output logic [BEAT_W-1:0] base_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] base_d,
  output logic [BEAT_W-1:0] beat_d
);

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    case (op)
      OP_LOAD: begin
        base_d = start_addr;
        beat_d = '0;
      end
      OP_ADVANCE: beat_d = BEAT_W'(beat_q + 1'b1);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  logic              order_ilv,
  output logic [BEAT_W-1:0] addr
);

  logic [BEAT_W-1:0] ilv_addr;
  logic [BEAT_W-1:0] lin_addr;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
    assign ilv_addr[b] = base[b] ^ beat[b];
  end

  // Carry out of the top bit is dropped: the wrap stays inside the group.
  assign lin_addr = BEAT_W'(base + beat);
  assign addr     = order_ilv ? ilv_addr : lin_addr;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BEAT_W-1:0] start_addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              chip_sel,
  input  logic              adv_n,
  input  logic              order_ilv,
  output logic [BEAT_W-1:0] burst_addr,
  output logic [BEAT_W-1:0] beat_idx
);

  burst_op_e         op;
  logic [BEAT_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] base_d;
  logic [BEAT_W-1:0] beat_d;
  logic [BEAT_W-1:0] addr_d;
  logic [BEAT_W-1:0] addr_q;

  burst_ctrl_decode u_decode (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .chip_sel      (chip_sel),
    .adv_n         (adv_n),
    .op            (op)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .start_addr (start_addr),
    .base_q     (base_q),
    .beat_q     (beat_q),
    .base_d     (base_d),
    .beat_d     (beat_d)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .base      (base_d),
    .beat      (beat_d),
    .order_ilv (order_ilv),
    .addr      (addr_d)
  );

  // The address is mapped from next state so the output is a flop, not logic.
  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_d;
  end

  assign burst_addr = addr_q;
  assign beat_idx   = beat_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [BEAT_W-1:0] start_addr,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              chip_sel,
  input logic              adv_n,
  input logic              order_ilv,
  input logic [BEAT_W-1:0] burst_addr,
  input logic [BEAT_W-1:0] beat_idx
);

  logic armed = 1'b0;
  logic strobe_seen;
  logic adv_cyc;
  logic hold_cyc;

  always_ff @(posedge clk) armed <= 1'b1;

  assign strobe_seen = ~proc_strobe_n | ~ctrl_strobe_n;
  assign adv_cyc     = ~strobe_seen & ~adv_n;
  assign hold_cyc    = ~strobe_seen & adv_n;

  a_r1_reset_clears: assert property (@(posedge clk)
    armed && $past(rst) |-> burst_addr == '0 && beat_idx == '0);

  a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(strobe_seen && chip_sel)
      |-> burst_addr == $past(start_addr) && beat_idx == '0);

  a_r3_deselect_holds: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(strobe_seen && !chip_sel)
      |-> $stable(burst_addr) && $stable(beat_idx));

  a_r4_beat_steps: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(adv_cyc)
      |-> beat_idx == BEAT_W'($past(beat_idx) + 1'b1));

  a_r5_ilv_step: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(adv_cyc) && order_ilv && $past(order_ilv)
      |-> burst_addr == ($past(burst_addr) ^ $past(beat_idx) ^ beat_idx));

  a_r6_lin_step: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(adv_cyc) && !order_ilv && !$past(order_ilv)
      |-> burst_addr == BEAT_W'($past(burst_addr) + 1'b1));

  a_r8_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(hold_cyc) && $stable(order_ilv)
      |-> $stable(burst_addr) && $stable(beat_idx));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] start_addr;
  logic       proc_strobe_n;
  logic       ctrl_strobe_n;
  logic       chip_sel;
  logic       adv_n;
  logic       order_ilv;
  logic [1:0] burst_addr;
  logic [1:0] beat_idx;

  int checks = 0;
  int errors = 0;
  int exp_base;
  int exp_beat;
  int exp_mode;

  always #4 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk           (clk),
    .rst           (rst),
    .start_addr    (start_addr),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .chip_sel      (chip_sel),
    .adv_n         (adv_n),
    .order_ilv     (order_ilv),
    .burst_addr    (burst_addr),
    .beat_idx      (beat_idx)
  );

  function automatic int exp_addr();
    if (exp_mode == 1) return (exp_base ^ exp_beat) & 3;
    return (exp_base + exp_beat) & 3;
  endfunction

  task automatic check(input string req);
    int ea;
    ea = exp_addr();
    checks++;
    if (burst_addr !== 2'(ea) || beat_idx !== 2'(exp_beat)) begin
      errors++;
      $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
               req, burst_addr, beat_idx, ea, exp_beat);
    end
  endtask

  task automatic step(input logic p_n, input logic c_n, input logic sel,
                      input logic a_n, input int sa);
    proc_strobe_n = p_n;
    ctrl_strobe_n = c_n;
    chip_sel      = sel;
    adv_n         = a_n;
    start_addr    = 2'(sa);
    @(posedge clk);
    @(negedge clk);
    proc_strobe_n = 1'b1;
    ctrl_strobe_n = 1'b1;
    adv_n         = 1'b1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start_addr = 2'd3; proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1;
    chip_sel = 1'b1; adv_n = 1'b1; order_ilv = 1'b1;
    exp_base = 0; exp_beat = 0; exp_mode = 1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R1 reset");
    rst = 1'b0;

    // Sweep both orders, every start, both strobes, with a suspend mid-burst.
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int which = 0; which < 2; which++) begin
          order_ilv = logic'(m);
          exp_mode  = m;
          step(logic'(which), logic'(!which), 1'b1, logic'(s & 1), s);
          exp_base = s; exp_beat = 0;
          check("R2 load");
          for (int k = 1; k <= 4; k++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0, 0);
            exp_beat = k & 3;
            check(m == 1 ? "R5 interleaved step" : "R6 linear step");
            if (k == 2) begin
              step(1'b1, 1'b1, 1'b1, 1'b1, 0);
              check("R8 suspend");
              step(1'b1, 1'b1, 1'b0, 1'b1, 0);
              check("R8 suspend deselected");
            end
          end
          check("R7 wrap to start");
          step(1'b1, 1'b1, 1'b1, 1'b0, 0);
          exp_beat = 1;
          check("R4 beat after wrap");
        end
      end
    end

    // Deselected strobes: no load and no advance.
    order_ilv = 1'b0; exp_mode = 0;
    step(1'b0, 1'b1, 1'b1, 1'b1, 1);
    exp_base = 1; exp_beat = 0;
    check("R2 load linear");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0);
    exp_beat = 1;
    check("R4 advance");
    for (int v = 0; v < 4; v++) begin
      step(logic'(v & 1), logic'(!(v & 1)), 1'b0, logic'(v >> 1), 3 - v);
      check("R3 deselected strobe ignored");
    end

    // Reload in the middle of a burst, with advance held low.
    step(1'b1, 1'b1, 1'b1, 1'b0, 0);
    exp_beat = 2;
    check("R4 advance");
    step(1'b1, 1'b0, 1'b1, 1'b0, 3);
    exp_base = 3; exp_beat = 0;
    check("R9 reload mid-burst");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0);
    exp_beat = 1;
    check("R9 new base step");

    // Reset in the middle of a burst.
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b0, 0);
    rst = 1'b0;
    exp_base = 0; exp_beat = 0;
    check("R1 reset mid-burst");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule